// File: doc/BRIEF.md
# Priority Reference Source Selector

This block picks one active clock reference out of up to fourteen candidates. Upstream monitors supply one validity bit per candidate. A small write port loads a 4-bit priority for each candidate, a 4-bit force field and a revertive-mode bit. From these the block produces the chosen channel number, a flag saying whether that choice is usable, and a one-cycle strobe whenever the chosen channel number changes.

In automatic mode the block takes the usable candidate with the smallest non-zero priority value. Candidates that share a priority value are served in the order in which they became usable. Candidates that become usable in the same cycle are ordered by channel number, lowest first. In non-revertive mode the block stays on the current source while that source remains usable. In revertive mode it moves to a strictly better source as soon as one appears. A loss of the current source always causes a move. A force field value that names a channel overrides all of this and ties the output to that channel.

Channels are numbered 1 to N on the index output. Index 0 means that nothing has been selected since reset. A candidate is *eligible* when its validity bit is high and its priority is non-zero.

Top module: `refsel_top`

## Requirements
- R1: When the force field holds a value n other than 0 and 15 (all ones), with 1 <= n <= N, then from the next clock edge `sel_idx_o` equals n and `sel_valid_o` equals `ref_valid_i[n-1]`. The priority of channel n is ignored.
- R2: After reset, `sel_idx_o` is 0 and `sel_valid_o` and `sel_switch_o` are 0. The force field resets to 15 (automatic), every priority resets to 0, and the revertive bit resets to 0 (non-revertive).
- R3: In automatic mode (force field 0 or 15), when there is no usable current selection, the next edge selects the eligible channel with the smallest priority value and raises `sel_valid_o`.
- R4: A channel whose priority is 0 is never selected in automatic mode, even when its validity bit is high.
- R5: If the selected channel stops being eligible while another channel is eligible, the next edge moves to the best eligible channel. This holds in both modes.
- R6: In non-revertive mode the index does not change while the selected channel stays eligible, even if a better channel is eligible.
- R7: In revertive mode, an eligible channel with a strictly smaller priority value than the current one causes a move on the next edge. An equal priority value never causes a move.
- R8: Among eligible channels of equal priority, the one that became eligible earliest wins. A channel that regains eligibility goes to the back of its group and causes no move. Channels that become eligible in the same cycle are ordered lowest channel number first.
- R9: In automatic mode, when no channel is eligible, `sel_valid_o` drops on the next edge and `sel_idx_o` keeps its last value.
- R10: `sel_switch_o` is high for exactly the cycle that follows each edge at which `sel_idx_o` changed, and is low otherwise.
- R11: A write with address k, for k below N, sets the priority of channel k+1 to `cfg_wdata_i`. Address N sets the force field. Address N+1 sets the revertive bit from `cfg_wdata_i[0]` (1 = revertive). A write takes effect at its edge and steers the decision made at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_valid_i | input | N | Validity bit per candidate; bit k is channel k+1 |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | ADDR_W | Configuration address (priorities, force field, mode) |
| cfg_wdata_i | input | 4 | Configuration write data |
| sel_idx_o | output | IDX_W | Selected channel number, 1..N (0 before the first selection) |
| sel_valid_o | output | 1 | Selection is usable |
| sel_switch_o | output | 1 | One-cycle strobe after the selected index changed |

## Verification
A corrupted arrival order would pick the wrong member of a tie group. This shows at the ports on the first edge at which that group's head fails, as a wrong `sel_idx_o` one cycle after the failing validity bit drops. A stale eligibility or priority in the decision path shows one edge later: the block either holds a dead source, which lowers `sel_valid_o` or skips the required move, or leaves a live one in non-revertive mode. The bench keeps its own timestamp-based model and compares index, flag and strobe after every edge. It does this under directed tie, failure and force scenarios and under long runs of random validity flips and configuration writes.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
  localparam int PRIO_W  = 4;
  localparam int FORCE_W = 4;
  typedef logic [PRIO_W-1:0] prio_t;

  function automatic logic is_auto(input logic [FORCE_W-1:0] f);
    return (f == '0) || (f == '1);
  endfunction
endpackage

// File: rtl/refsel_cfg.sv
module refsel_cfg
  import refsel_pkg::*;
#(
  parameter int N      = 14,
  parameter int ADDR_W = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [PRIO_W-1:0]         wdata_i,
  output logic [N-1:0][PRIO_W-1:0]  prio_o,
  output logic [FORCE_W-1:0]        force_o,
  output logic                      rev_o
);
  localparam logic [ADDR_W-1:0] FORCE_ADDR = ADDR_W'(N);
  localparam logic [ADDR_W-1:0] MODE_ADDR  = ADDR_W'(N + 1);

  for (genvar k = 0; k < N; k++) begin : g_prio
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 prio_o[k] <= '0;
      else if (we_i && addr_i == ADDR_W'(k))       prio_o[k] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      force_o <= '1;
      rev_o   <= 1'b0;
    end else if (we_i) begin
      if (addr_i == FORCE_ADDR) force_o <= FORCE_W'(wdata_i);
      if (addr_i == MODE_ADDR)  rev_o   <= wdata_i[0];
    end
  end
endmodule

// File: rtl/refsel_age.sv
// Arrival-order matrix: older_o[a][b] = channel a became eligible before b.
module refsel_age #(
  parameter int N = 14
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N-1:0]         elig_i,
  output logic [N-1:0][N-1:0]  older_o
);
  logic [N-1:0]         elig_q;
  logic [N-1:0]         rise;
  logic [N-1:0][N-1:0]  age_q;

  assign rise = elig_i & ~elig_q;

  for (genvar a = 0; a < N; a++) begin : g_row
    for (genvar b = 0; b < N; b++) begin : g_col
      if (a == b) begin : g_diag
        assign older_o[a][b] = 1'b0;
      end else begin : g_pair
        always_comb begin
          unique case ({rise[a], rise[b]})
            2'b11:   older_o[a][b] = (a < b);  // same-cycle arrivals
            2'b10:   older_o[a][b] = 1'b0;
            2'b01:   older_o[a][b] = 1'b1;
            default: older_o[a][b] = age_q[a][b];
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      elig_q <= '0;
      age_q  <= '0;
    end else begin
      elig_q <= elig_i;
      age_q  <= older_o;
    end
  end
endmodule

// File: rtl/refsel_pick.sv
module refsel_pick
  import refsel_pkg::*;
#(
  parameter int N     = 14,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]              elig_i,
  input  logic [N-1:0][PRIO_W-1:0]  prio_i,
  input  logic [N-1:0][N-1:0]       older_i,
  output logic                      found_o,
  output logic [IDX_W-1:0]          idx_o,
  output logic [PRIO_W-1:0]         prio_o
);
  logic [N-1:0][N-1:0] beats;  // beats[a][b]: a ranks above b
  logic [N-1:0]        win;

  for (genvar a = 0; a < N; a++) begin : g_a
    for (genvar b = 0; b < N; b++) begin : g_b
      if (a == b) begin : g_self
        assign beats[a][b] = 1'b0;
      end else begin : g_cmp
        assign beats[a][b] = elig_i[a] &&
          ((prio_i[a] < prio_i[b]) ||
           ((prio_i[a] == prio_i[b]) && older_i[a][b]));
      end
    end
  end

  always_comb begin
    win = elig_i;
    for (int a = 0; a < N; a++)
      for (int b = 0; b < N; b++)
        if (beats[a][b]) win[b] = 1'b0;
  end

  always_comb begin
    found_o = |win;
    idx_o   = '0;
    prio_o  = '0;
    for (int k = 0; k < N; k++) begin
      if (win[k]) begin
        idx_o  = idx_o  | IDX_W'(k + 1);
        prio_o = prio_o | prio_i[k];
      end
    end
  end
endmodule

// File: rtl/refsel_top.sv
// N is limited to 1..14 so every channel number fits the 4-bit force field.
module refsel_top
  import refsel_pkg::*;
#(
  parameter int N      = 14,
  parameter int IDX_W  = $clog2(N + 1),
  parameter int ADDR_W = $clog2(N + 2)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N-1:0]       ref_valid_i,
  input  logic               cfg_we_i,
  input  logic [ADDR_W-1:0]  cfg_addr_i,
  input  logic [PRIO_W-1:0]  cfg_wdata_i,
  output logic [IDX_W-1:0]   sel_idx_o,
  output logic               sel_valid_o,
  output logic               sel_switch_o
);
  logic [N-1:0][PRIO_W-1:0] prio_q;
  logic [FORCE_W-1:0]       force_q;
  logic                     rev_q;
  logic [N-1:0]             elig;
  logic [N-1:0][N-1:0]      older;
  logic                     best_found;
  logic [IDX_W-1:0]         best_idx;
  logic [PRIO_W-1:0]        best_prio;

  logic [IDX_W-1:0] sel_idx_q, idx_d;
  logic             sel_valid_q, vld_d, switch_q;
  logic             auto_mode, cur_elig, frc_ok, frc_valid;
  logic [PRIO_W-1:0] cur_prio;

  refsel_cfg #(.N(N), .ADDR_W(ADDR_W)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .prio_o  (prio_q),
    .force_o (force_q),
    .rev_o   (rev_q)
  );

  for (genvar k = 0; k < N; k++) begin : g_elig
    assign elig[k] = ref_valid_i[k] && (prio_q[k] != '0);
  end

  refsel_age #(.N(N)) u_age (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .elig_i  (elig),
    .older_o (older)
  );

  refsel_pick #(.N(N), .IDX_W(IDX_W)) u_pick (
    .elig_i  (elig),
    .prio_i  (prio_q),
    .older_i (older),
    .found_o (best_found),
    .idx_o   (best_idx),
    .prio_o  (best_prio)
  );

  always_comb begin
    auto_mode = is_auto(force_q);
    cur_elig  = 1'b0;
    cur_prio  = '0;
    frc_ok    = 1'b0;
    frc_valid = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (sel_idx_q == IDX_W'(k + 1)) begin
        cur_elig = elig[k];
        cur_prio = prio_q[k];
      end
      if (force_q == FORCE_W'(k + 1)) begin
        frc_ok    = 1'b1;
        frc_valid = ref_valid_i[k];
      end
    end
  end

  always_comb begin
    idx_d = sel_idx_q;
    vld_d = 1'b0;
    if (!auto_mode) begin
      if (frc_ok) begin
        idx_d = IDX_W'(force_q);
        vld_d = frc_valid;
      end
    end else if (sel_valid_q && cur_elig &&
                 !(rev_q && best_found && (best_prio < cur_prio))) begin
      vld_d = 1'b1;  // keep current source
    end else if (best_found) begin
      idx_d = best_idx;
      vld_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_idx_q   <= '0;
      sel_valid_q <= 1'b0;
      switch_q    <= 1'b0;
    end else begin
      sel_idx_q   <= idx_d;
      sel_valid_q <= vld_d;
      switch_q    <= (idx_d != sel_idx_q);
    end
  end

  assign sel_idx_o    = sel_idx_q;
  assign sel_valid_o  = sel_valid_q;
  assign sel_switch_o = switch_q;
endmodule

// File: rtl/refsel_chk.sv
module refsel_chk
  import refsel_pkg::*;
#(
  parameter int N     = 14,
  parameter int IDX_W = 4
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [N-1:0]              ref_valid_i,
  input logic [N-1:0][PRIO_W-1:0]  prio_i,
  input logic [FORCE_W-1:0]        force_i,
  input logic                      rev_i,
  input logic [IDX_W-1:0]          sel_idx_o,
  input logic                      sel_valid_o,
  input logic                      sel_switch_o
);
  logic auto_m, cur_ok, any_ok, frc_in;

  always_comb begin
    auto_m = is_auto(force_i);
    cur_ok = 1'b0;
    any_ok = 1'b0;
    frc_in = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (ref_valid_i[k] && prio_i[k] != '0) begin
        any_ok = 1'b1;
        if (sel_idx_o == IDX_W'(k + 1)) cur_ok = 1'b1;
      end
      if (force_i == FORCE_W'(k + 1)) frc_in = 1'b1;
    end
  end

  AST_SWITCH_ON_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_switch_o == (sel_idx_o != $past(sel_idx_o)));  // R10

  AST_VALID_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_valid_o |-> (sel_idx_o >= IDX_W'(1) && sel_idx_o <= IDX_W'(N)));  // R3

  AST_FAIL_FORCES_SWITCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_m && sel_valid_o && !cur_ok && any_ok |=> sel_idx_o != $past(sel_idx_o));  // R5

  AST_NONREV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_m && !rev_i && sel_valid_o && cur_ok |=> $stable(sel_idx_o) && sel_valid_o);  // R6

  AST_NONE_DROPS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_m && !any_ok |=> !sel_valid_o && $stable(sel_idx_o));  // R9

  AST_FORCED_INDEX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_m && frc_in |=> sel_idx_o == IDX_W'($past(force_i)));  // R1
endmodule

bind refsel_top refsel_chk #(.N(N), .IDX_W(IDX_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ref_valid_i  (ref_valid_i),
  .prio_i       (prio_q),
  .force_i      (force_q),
  .rev_i        (rev_q),
  .sel_idx_o    (sel_idx_o),
  .sel_valid_o  (sel_valid_o),
  .sel_switch_o (sel_switch_o)
);

// File: tb/sim_refsel_top.sv
`timescale 1ns/1ps
module sim_refsel_top;
  localparam int N      = 14;
  localparam int IDX_W  = 4;
  localparam int ADDR_W = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [N-1:0]      ref_valid = '0;
  logic              cfg_we = 1'b0;
  logic [ADDR_W-1:0] cfg_addr = '0;
  logic [3:0]        cfg_wdata = '0;
  logic [IDX_W-1:0]  sel_idx;
  logic              sel_valid, sel_switch;

  always #2.5 clk = ~clk;

  refsel_top #(.N(N)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ref_valid_i(ref_valid),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .sel_idx_o(sel_idx), .sel_valid_o(sel_valid), .sel_switch_o(sel_switch)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model
  int     m_prio [N];
  int     m_force;
  bit     m_rev;
  bit     m_prev [N];
  longint m_stamp [N];
  longint m_tick;
  int     m_idx;
  bit     m_vld;

  task automatic check(input string tag, input int got, input int exp, input string what);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < N; k++) begin
      m_prio[k] = 0; m_prev[k] = 0; m_stamp[k] = 0;
    end
    m_force = 15; m_rev = 0; m_tick = 0; m_idx = 0; m_vld = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ref_valid = '0; cfg_we = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    model_reset();
    check("R2", sel_idx, 0, "index");
    check("R2", sel_valid, 0, "valid");
    check("R2", sel_switch, 0, "switch");
    rst_n = 1'b1;
  endtask

  task automatic step(input logic [N-1:0] v, input bit we, input int addr,
                      input int data, input string tag);
    bit     el [N];
    bit     found;
    int     best, bp, nidx;
    longint bs;
    bit     nvld, cur_ok;
    string  rule, t;
    ref_valid = v; cfg_we = we; cfg_addr = ADDR_W'(addr); cfg_wdata = 4'(data);
    found = 0; best = 0; bp = 99; bs = 0;
    for (int k = 0; k < N; k++) begin
      el[k] = v[k] && (m_prio[k] != 0);
      if (el[k] && !m_prev[k]) m_stamp[k] = m_tick * 64 + k;
      m_prev[k] = el[k];
    end
    m_tick++;
    for (int k = 0; k < N; k++)
      if (el[k] && (!found || m_prio[k] < bp || (m_prio[k] == bp && m_stamp[k] < bs))) begin
        found = 1; best = k + 1; bp = m_prio[k]; bs = m_stamp[k];
      end
    nidx = m_idx; nvld = 0;
    if (m_force != 0 && m_force != 15) begin
      rule = "R1";
      if (m_force <= N) begin nidx = m_force; nvld = v[m_force-1]; end
    end else begin
      cur_ok = m_vld && m_idx >= 1 && m_idx <= N && el[m_idx-1];
      if (cur_ok && !(m_rev && found && bp < m_prio[m_idx-1])) begin
        nvld = 1; rule = m_rev ? "R7" : "R6";
      end else if (found) begin
        nidx = best; nvld = 1;
        rule = cur_ok ? "R7" : (m_vld ? "R5" : "R3");
      end else rule = "R9";
    end
    if (we) begin
      if (addr < N) m_prio[addr] = data;
      else if (addr == N) m_force = data;
      else if (addr == N + 1) m_rev = data[0];
    end
    @(posedge clk); #1;
    t = (tag == "") ? rule : tag;
    check(t, sel_idx, nidx, "index");
    check(t, sel_valid, nvld, "valid");
    check("R10", sel_switch, (nidx != m_idx), "switch");
    m_idx = nidx; m_vld = nvld;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [N-1:0] ch(input int c);
    return N'(1) << (c - 1);
  endfunction

  localparam logic [N-1:0] ALL = '1;

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] v;
    void'($urandom(32'd7741));
    // block A: register map, priority, modes, force
    do_reset();
    step('0, 1, 2, 5, "R11");                 // ch3 prio 5
    step('0, 1, 6, 2, "R11");                 // ch7 prio 2
    step(ALL, 0, 0, 0, "R3");                 // picks ch7
    check("R3", sel_idx, 7, "index literal");
    step(ALL, 1, 4, 1, "R6");                 // ch5 prio 1
    step(ALL, 0, 0, 0, "R6");                 // better ch5 seen, held
    check("R6", sel_idx, 7, "index literal");
    step(ALL & ~ch(7), 0, 0, 0, "R5");        // ch7 lost -> ch5
    check("R5", sel_idx, 5, "index literal");
    step(ALL & ~ch(7), 1, N + 1, 1, "R11");   // revertive on
    step(ALL & ~ch(7) & ~ch(5), 0, 0, 0, "R5");
    check("R5", sel_idx, 3, "index literal");
    step(ALL & ~ch(5), 0, 0, 0, "R7");        // ch7 back, better
    check("R7", sel_idx, 7, "index literal");
    step(ALL & ~ch(5), 1, 1, 2, "R7");        // ch2 prio 2 (equal)
    step(ALL & ~ch(5), 0, 0, 0, "R7");
    check("R7", sel_idx, 7, "equal prio held");
    step(ch(1), 0, 0, 0, "R4");               // only ch1 (prio 0)
    check("R4", sel_valid, 0, "prio zero ignored");
    step(ch(1), 1, N, 1, "R9");               // force ch1
    step(ch(1), 0, 0, 0, "R1");
    check("R1", sel_idx, 1, "forced index");
    step('0, 0, 0, 0, "R1");
    step('0, 1, N, 0, "R1");                  // back to automatic
    step(ch(7), 0, 0, 0, "R3");
    // block B: equal-priority arrival order
    do_reset();
    step('0, 1, 9, 4, "R11");
    step('0, 1, 3, 4, "R11");
    step('0, 1, 11, 4, "R11");
    step(ch(10), 0, 0, 0, "R8");
    step(ch(10) | ch(4), 0, 0, 0, "R8");
    step(ch(4), 0, 0, 0, "R8");
    check("R8", sel_idx, 4, "index literal");
    step(ch(4) | ch(10), 0, 0, 0, "R8");      // ch10 rejoins at tail
    step(ch(10), 0, 0, 0, "R8");
    check("R8", sel_idx, 10, "index literal");
    step('0, 0, 0, 0, "R9");
    check("R9", sel_idx, 10, "index held");
    step(ch(12) | ch(4), 0, 0, 0, "R8");      // same-cycle arrival
    check("R8", sel_idx, 4, "lower channel first");
    step(ch(12), 1, N + 1, 1, "R8");
    step(ch(12) | ch(4), 0, 0, 0, "R8");
    check("R8", sel_idx, 12, "revertive ignores tie");
    // block C: random
    do_reset();
    for (int k = 0; k < N; k++) step('0, 1, k, $urandom_range(0, 15), "R11");
    v = '0;
    for (int i = 0; i < 4000; i++) begin
      int a, d;
      bit w;
      for (int k = 0; k < N; k++) if ($urandom_range(0, 7) == 0) v[k] = ~v[k];
      w = ($urandom_range(0, 9) == 0);
      a = $urandom_range(0, N + 1);
      d = $urandom_range(0, 15);
      if (a == N && $urandom_range(0, 9) < 7) d = $urandom_range(0, 1) ? 15 : 0;
      step(v, w, a, d, "");
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule